// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block collects one-cycle request pulses from sixteen interrupt sources: video, audio, the two timers, the ADC, the serial ports, external pins, tickers, the timebases, low-voltage and key-change. Each pulse is latched into a pending bit. A pending bit counts only when its enable bit is also set. The block groups the unmasked sources onto eight prioritised request lines. It drives the CPU's normal interrupt request with the 16-bit vector address of the most urgent line. One selectable source can instead be steered to the fast interrupt request, which takes priority over every line.

Software reaches the block through a small register port with four addresses: enable mask, pending status, write-one-to-clear, and fast-interrupt select. Enable, status and clear share one bit layout, so bit `n` always means source `n`. Vector addresses are 16 bits wide, so every handler entry lies in the first 64K-word segment.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the pending, enable and fast-select registers read 0, `irq_req` and `fiq_req` are 0 and `vec_addr` is 16'h0000. Reset is asserted asynchronously and released through a two-stage synchroniser.
- R2: A 1 on `src_pulse[n]` at a rising edge sets pending bit n. The bit can be read at address 1 from the following cycle on.
- R3: Writing address 2 clears every pending bit whose `reg_wdata` bit is 1 and leaves the others alone. A pulse on the same bit in the same cycle keeps that bit set.
- R4: Writes to address 1 (status) change nothing. Address 2 reads back as 0.
- R5: Source bits map to request lines as follows. Line 0: bit 15. Line 1: bit 14. Line 2: bits 12 and 11. Line 3: bits 13, 10 and 5. Line 4: bit 7. Line 5: bits 9 and 8. Line 6: bit 6. Line 7: bits 4, 3, 2, 1 and 0. A line is active when any of its sources is pending and enabled. `irq_req` is 1 when any line is active.
- R6: Address 0 is the read/write enable mask. A pending bit whose enable bit is 0 stays pending but drives no request.
- R7: With no fast request active, `vec_addr` is 16'hFFF8 plus the number of the lowest-numbered active line.
- R8: Address 3 bits [3:0] select a source and bit 4 arms the routing. While armed, that source drives `fiq_req` and not its line. Whenever `fiq_req` is 1, `vec_addr` is 16'hFFF6.
- R9: With no active line and no fast request, `vec_addr` is 16'h0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_pulse | input | 16 | One-cycle request pulse per source |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 enable, 1 status, 2 clear, 3 fast select) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| irq_req | output | 1 | Normal interrupt request |
| fiq_req | output | 1 | Fast interrupt request |
| vec_addr | output | 16 | Vector address of the winning request |

## Verification
The bench pulses each of the sixteen sources alone and checks the vector it produces. A wrong entry in the line map shows up there as a wrong vector address. It also raises two lines at once to check that the lower line number wins; an inverted priority encoder would return the higher vector. It clears a bit in the same cycle as a new pulse on that bit, which a design with clear-over-set ordering would lose. Further steps check that the fast-select source leaves its own line and forces 16'hFFF6. They also check that a masked source stays pending but silent, and that writes to the status address are ignored.

// File: rtl/irqvec_pkg.sv
package irqvec_pkg;
  localparam int unsigned SRC_N  = 16;
  localparam int unsigned LINE_N = 8;
  localparam int unsigned VEC_W  = 16;
  localparam int unsigned SEL_W  = $clog2(SRC_N);
  localparam int unsigned LINE_W = $clog2(LINE_N);

  localparam logic [VEC_W-1:0] VEC_FIQ  = 16'hFFF6;
  localparam logic [VEC_W-1:0] VEC_BASE = 16'hFFF8;
  localparam logic [VEC_W-1:0] VEC_NONE = 16'h0000;

  typedef enum logic [1:0] {
    RA_ENABLE = 2'd0,
    RA_STATUS = 2'd1,
    RA_CLEAR  = 2'd2,
    RA_FIQSEL = 2'd3
  } reg_addr_e;

  // Request line that each source bit feeds
  function automatic int unsigned line_of(int unsigned src);
    case (src)
      15:           return 0;
      14:           return 1;
      12, 11:       return 2;
      13, 10, 5:    return 3;
      7:            return 4;
      9, 8:         return 5;
      6:            return 6;
      default:      return 7;
    endcase
  endfunction

  // Mask of the sources that feed one line
  function automatic logic [SRC_N-1:0] members_of(int unsigned line);
    logic [SRC_N-1:0] m;
    m = '0;
    for (int unsigned s = 0; s < SRC_N; s++)
      if (line_of(s) == line) m[s] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/irqvec_regs.sv
module irqvec_regs
  import irqvec_pkg::*;
#(
  parameter int unsigned N_SRC = SRC_N,
  parameter int unsigned S_W   = SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_pulse,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [N_SRC-1:0] reg_wdata,
  output logic [N_SRC-1:0] reg_rdata,
  output logic [N_SRC-1:0] status_q,
  output logic [N_SRC-1:0] enable_q,
  output logic             fsel_valid_q,
  output logic [S_W-1:0]   fsel_idx_q
);
  logic [N_SRC-1:0] status_d, enable_d, clr_mask;
  logic             fsel_valid_d;
  logic [S_W-1:0]   fsel_idx_d;
  logic             wr_en, wr_clr, wr_fsel;
  logic             armed_q;

  // next state
  always_comb begin
    wr_en    = reg_we && (reg_addr == RA_ENABLE);
    wr_clr   = reg_we && (reg_addr == RA_CLEAR);
    wr_fsel  = reg_we && (reg_addr == RA_FIQSEL);
    clr_mask = wr_clr ? reg_wdata : '0;
    status_d = (status_q & ~clr_mask) | src_pulse;
    enable_d = wr_en ? reg_wdata : enable_q;
    fsel_valid_d = wr_fsel ? reg_wdata[S_W] : fsel_valid_q;
    fsel_idx_d   = wr_fsel ? reg_wdata[S_W-1:0] : fsel_idx_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q     <= '0;
      enable_q     <= '0;
      fsel_valid_q <= 1'b0;
      fsel_idx_q   <= '0;
      armed_q      <= 1'b0;
    end else begin
      status_q     <= status_d;
      armed_q      <= 1'b1;
      if (wr_en)   enable_q <= enable_d;
      if (wr_fsel) begin
        fsel_valid_q <= fsel_valid_d;
        fsel_idx_q   <= fsel_idx_d;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      RA_ENABLE: reg_rdata = enable_q;
      RA_STATUS: reg_rdata = status_q;
      RA_FIQSEL: reg_rdata = {{(N_SRC-S_W-1){1'b0}}, fsel_valid_q, fsel_idx_q};
      default:   reg_rdata = '0;
    endcase
  end

  // R2: every pulse leaves its pending bit set
  p_pulse_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> ((status_q & $past(src_pulse)) == $past(src_pulse)));

  // R3: cleared bits without a coincident pulse are gone
  p_clear_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(reg_we) && $past(reg_addr) == RA_CLEAR)
      |-> ((status_q & $past(reg_wdata) & ~$past(src_pulse)) == '0));

  // R4: status changes only by pulses or clears
  p_status_ro_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(src_pulse) == '0 &&
     !($past(reg_we) && $past(reg_addr) == RA_CLEAR)) |-> $stable(status_q));
endmodule

// File: rtl/irqvec_route.sv
module irqvec_route
  import irqvec_pkg::*;
#(
  parameter int unsigned N_SRC  = SRC_N,
  parameter int unsigned N_LINE = LINE_N,
  parameter int unsigned S_W    = SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  status_q,
  input  logic [N_SRC-1:0]  enable_q,
  input  logic              fsel_valid,
  input  logic [S_W-1:0]    fsel_idx,
  output logic [N_LINE-1:0] line_act,
  output logic              fiq_act
);
  logic [N_SRC-1:0] active, fiq_mask, irq_src;

  always_comb begin
    active   = status_q & enable_q;
    fiq_mask = fsel_valid ? (N_SRC'(1) << fsel_idx) : '0;
    fiq_act  = |(active & fiq_mask);
    irq_src  = active & ~fiq_mask;
  end

  for (genvar l = 0; l < N_LINE; l++) begin : g_line
    localparam logic [N_SRC-1:0] MEMBERS = members_of(l);
    assign line_act[l] = |(irq_src & MEMBERS);
  end

  // R8: fast request only while routing is armed
  p_fiq_needs_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_act |-> fsel_valid);

  // R6: no request without an enabled pending source
  p_masked_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & enable_q) == '0) |-> (line_act == '0 && !fiq_act));
endmodule

// File: rtl/irqvec_prio.sv
module irqvec_prio
  import irqvec_pkg::*;
#(
  parameter int unsigned N_LINE = LINE_N,
  parameter int unsigned V_W    = VEC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_LINE-1:0] line_act,
  input  logic              fiq_act,
  output logic              irq_req,
  output logic              fiq_req,
  output logic [V_W-1:0]    vec_addr
);
  localparam int unsigned L_W = $clog2(N_LINE);
  logic [L_W-1:0] win;

  always_comb begin
    win = '0;
    for (int l = N_LINE - 1; l >= 0; l--)
      if (line_act[l]) win = L_W'(l);
    irq_req = |line_act;
    fiq_req = fiq_act;
    if (fiq_act)       vec_addr = VEC_FIQ;
    else if (irq_req)  vec_addr = VEC_BASE + V_W'(win);
    else               vec_addr = VEC_NONE;
  end

  // R8: fast request owns the vector
  p_fiq_vector_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_req |-> vec_addr == VEC_FIQ);

  // R7: chosen line is active and no lower line is
  p_lowest_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !fiq_req) |->
      (line_act[vec_addr[L_W-1:0]] &&
       (line_act & ((N_LINE'(1) << vec_addr[L_W-1:0]) - N_LINE'(1))) == '0));

  // R9: idle vector
  p_idle_vec_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_req && !fiq_req) |-> vec_addr == VEC_NONE);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqvec_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] src_pulse,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        irq_req,
  output logic        fiq_req,
  output logic [15:0] vec_addr
);
  logic [1:0]        rst_sync_q;
  logic              rst_s_n;
  logic [SRC_N-1:0]  status_q, enable_q;
  logic              fsel_valid;
  logic [SEL_W-1:0]  fsel_idx;
  logic [LINE_N-1:0] line_act;
  logic              fiq_act;

  // R1: asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  irqvec_regs #(.N_SRC(SRC_N), .S_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_s_n), .src_pulse(src_pulse), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .status_q(status_q), .enable_q(enable_q),
    .fsel_valid_q(fsel_valid), .fsel_idx_q(fsel_idx)
  );

  irqvec_route #(.N_SRC(SRC_N), .N_LINE(LINE_N), .S_W(SEL_W)) u_route (
    .clk(clk), .rst_n(rst_s_n), .status_q(status_q), .enable_q(enable_q),
    .fsel_valid(fsel_valid), .fsel_idx(fsel_idx),
    .line_act(line_act), .fiq_act(fiq_act)
  );

  irqvec_prio #(.N_LINE(LINE_N), .V_W(VEC_W)) u_prio (
    .clk(clk), .rst_n(rst_s_n), .line_act(line_act), .fiq_act(fiq_act),
    .irq_req(irq_req), .fiq_req(fiq_req), .vec_addr(vec_addr)
  );

  // R1: nothing requested while held in reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_s_n |-> (!irq_req && !fiq_req && vec_addr == 16'h0000));
endmodule

// File: tb/test_irq_vector_ctrl.sv
module test_irq_vector_ctrl;
  localparam time CLK_PERIOD = 10ns;

  typedef struct {
    string       req;
    logic [15:0] rd;
    logic        irq;
    logic        fiq;
    logic [15:0] vec;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] src_pulse;
  logic        reg_we;
  logic [1:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        irq_req, fiq_req;
  logic [15:0] vec_addr;

  exp_t        sb[$];
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  // bench reference state, built from the requirements
  logic [15:0] m_stat = '0, m_en = '0;
  logic [4:0]  m_fsel = '0;

  irq_vector_ctrl i_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_req(irq_req), .fiq_req(fiq_req), .vec_addr(vec_addr)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int ref_line(int s);
    case (s)
      15: return 0;
      14: return 1;
      12, 11: return 2;
      13, 10, 5: return 3;
      7: return 4;
      9, 8: return 5;
      6: return 6;
      default: return 7;
    endcase
  endfunction

  function automatic exp_t predict(string tag, logic [1:0] ra);
    exp_t e;
    logic [15:0] act;
    logic [7:0]  lines;
    e.req = tag;
    act = m_stat & m_en;
    e.fiq = m_fsel[4] && act[m_fsel[3:0]];
    lines = '0;
    for (int s = 0; s < 16; s++)
      if (act[s] && !(m_fsel[4] && m_fsel[3:0] == s[3:0])) lines[ref_line(s)] = 1'b1;
    e.irq = |lines;
    e.vec = 16'h0000;
    if (e.fiq) e.vec = 16'hFFF6;
    else for (int l = 7; l >= 0; l--) if (lines[l]) e.vec = 16'hFFF8 + 16'(l);
    case (ra)
      2'd0: e.rd = m_en;
      2'd1: e.rd = m_stat;
      2'd2: e.rd = 16'h0000;
      default: e.rd = {11'd0, m_fsel};
    endcase
    return e;
  endfunction

  // driver: one cycle of stimulus, then queue the expected outcome
  task automatic step(logic [15:0] src, logic we, logic [1:0] wa,
                      logic [15:0] wd, logic [1:0] ra, string tag);
    logic [15:0] clr;
    @(negedge clk); #1;
    src_pulse = src; reg_we = we; reg_addr = wa; reg_wdata = wd;
    clr = (we && wa == 2'd2) ? wd : 16'h0000;
    m_stat = (m_stat & ~clr) | src;
    if (we && wa == 2'd0) m_en = wd;
    if (we && wa == 2'd3) m_fsel = wd[4:0];
    @(posedge clk); #2;
    src_pulse = '0; reg_we = 1'b0; reg_addr = ra;
    sb.push_back(predict(tag, ra));
  endtask

  // monitor: compare at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        n_chk++;
        if (reg_rdata !== e.rd || irq_req !== e.irq || fiq_req !== e.fiq ||
            vec_addr !== e.vec) begin
          n_fail++;
          $display("FAIL %s: rd=%h irq=%b fiq=%b vec=%h expected rd=%h irq=%b fiq=%b vec=%h",
                   e.req, reg_rdata, irq_req, fiq_req, vec_addr,
                   e.rd, e.irq, e.fiq, e.vec);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; src_pulse = '0; reg_we = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
    repeat (4) @(negedge clk);
    // R1: outputs quiet during reset
    sb.push_back(predict("R1", 2'd0));
    @(negedge clk); #1;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    step('0, 1'b0, 2'd0, '0, 2'd1, "R1");
    step('0, 1'b0, 2'd0, '0, 2'd3, "R1");
    // R2 / R6: masked pulse is recorded, no request
    step(16'h0001, 1'b0, 2'd0, '0, 2'd1, "R2");
    step('0, 1'b1, 2'd0, 16'h0000, 2'd1, "R6");
    // R5: enabling exposes line 7
    step('0, 1'b1, 2'd0, 16'hFFFF, 2'd0, "R5");
    // R7: ADC (line 3) beats line 7, then bit 15 (line 0)
    step(16'h2000, 1'b0, 2'd0, '0, 2'd1, "R7");
    step(16'h8000, 1'b0, 2'd0, '0, 2'd1, "R7");
    // R3: clear bit 15
    step('0, 1'b1, 2'd2, 16'h8000, 2'd1, "R3");
    // R4: status write ignored, clear reads 0
    step('0, 1'b1, 2'd1, 16'h0000, 2'd1, "R4");
    step('0, 1'b0, 2'd0, '0, 2'd2, "R4");
    // R8: route ADC to the fast request
    step('0, 1'b1, 2'd3, 16'h001D, 2'd3, "R8");
    // R3: clear and pulse together keep the bit
    step(16'h2000, 1'b1, 2'd2, 16'h2000, 2'd1, "R3");
    // R6: masking removes requests but keeps pending bits
    step('0, 1'b1, 2'd0, 16'h0000, 2'd1, "R6");
    step('0, 1'b1, 2'd0, 16'hFFFF, 2'd1, "R6");
    // R9: clear everything
    step('0, 1'b1, 2'd2, 16'hFFFF, 2'd1, "R9");
    // R8: disarm and show ADC back on line 3
    step('0, 1'b1, 2'd3, 16'h000D, 2'd3, "R8");
    step(16'h2000, 1'b0, 2'd0, '0, 2'd1, "R8");
    step('0, 1'b1, 2'd2, 16'hFFFF, 2'd1, "R9");
    // R5: each source alone
    for (int s = 0; s < 16; s++) begin
      step(16'(1) << s, 1'b0, 2'd0, '0, 2'd1, "R5");
      step('0, 1'b1, 2'd2, 16'hFFFF, 2'd1, "R9");
    end
    // R7: line 5 beats line 6, line 2 beats both
    step(16'h0040, 1'b0, 2'd0, '0, 2'd1, "R7");
    step(16'h0200, 1'b0, 2'd0, '0, 2'd1, "R7");
    step(16'h0800, 1'b0, 2'd0, '0, 2'd1, "R7");
    step('0, 1'b1, 2'd2, 16'h0800, 2'd1, "R7");
    step('0, 1'b1, 2'd2, 16'hFFFF, 2'd1, "R9");
    // R8: fast request with an unrelated line pending
    step('0, 1'b1, 2'd3, 16'h0010, 2'd3, "R8");
    step(16'h4001, 1'b0, 2'd0, '0, 2'd1, "R8");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule